// File: doc/BRIEF.md
# Write-Busy Acknowledge Polling Responder

This block is the slave-address front end of a two-wire serial target that holds nonvolatile storage. A bit-level bus engine hands it decoded bus events: start, stop, and each received address byte. For every address byte the block decides whether to acknowledge it. A command decoder signals when the open write transaction carries a nonvolatile write. When that transaction ends with a clean stop, the block enters a programming cycle. A clock-cycle counter times this cycle and stands in for the internal programming timer.

While the programming cycle runs, the block ignores every read and write command. It shows that it is busy only by withholding the acknowledge on its own address, whatever the R/W bit is. A bus master finds out when the cycle has ended by sending a start and the address byte again until an acknowledge comes back. This is called acknowledge polling. Once the address is acknowledged, the command enable goes high and downstream command logic may proceed.

The address byte arrives as a one-cycle `addr_valid` beat. There is no ready signal. The block accepts a byte on every cycle and never applies back-pressure, so the bus engine must not present a byte in the same cycle as a start or a stop. The acknowledge decision comes back as a one-cycle `ack_valid` beat, and the bus engine must take it in that cycle.

Top module: `nvp_poll_responder`

## Requirements
- R1: After reset, `busy`, `ack_valid`, `ack` and `cmd_en` are all low.
- R2: The address byte is laid out as follows: bits [7:4] hold the device-type identifier, bits [3:1] hold the device select, and bit 0 is R/W. One cycle after `addr_valid`, `ack_valid` is high for exactly one cycle, and `ack` is 1 only when bits [7:1] match the configured fields and no programming cycle is running.
- R3: The R/W bit (bit 0) has no effect on the acknowledge decision.
- R4: An address byte whose bits [7:1] do not match is never acknowledged, whether the block is busy or idle.
- R5: `cmd_en` rises in the cycle that an acknowledge is issued. It falls one cycle after a start or a stop.
- R6: A `nv_write_req` strobe that arrives while `cmd_en` is high arms a programming cycle. A stop that arrives while a cycle is armed raises `busy` one cycle later.
- R7: A start that arrives before the stop cancels the armed cycle. A stop with nothing armed does not raise `busy`.
- R8: `busy` stays high for exactly NV_CYCLES consecutive cycles, where NV_CYCLES = (CLK_HZ/1000)*NV_TIME_US/1000. It then falls cleanly.
- R9: While `busy` is high, a matching address is answered with `ack`=0, `cmd_en` stays low, and `nv_write_req` has no effect.
- R10: The first matching poll after `busy` falls is acknowledged, whatever the R/W value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| addr_valid | input | 1 | Address byte beat valid |
| addr_byte | input | 8 | Received address byte |
| nv_write_req | input | 1 | The open write targets nonvolatile storage (pulse) |
| ack_valid | output | 1 | Acknowledge decision beat |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| busy | output | 1 | Programming cycle running |
| cmd_en | output | 1 | Command processing enabled |

## Verification
Every result is registered, so each one is due exactly one clock edge after the input that causes it. An address beat leads to `ack_valid`/`ack` on the next cycle. A start, a stop or an acknowledge leads to the new `cmd_en` on the next cycle. A stop with a cycle armed leads to `busy` on the next cycle, and `busy` then holds for NV_CYCLES edges. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge and compares all four outputs on every falling edge. Directed checks sample on the falling edge that follows the rising edge that consumed their stimulus.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef struct packed {
    logic [3:0] dev_type;
    logic [2:0] dev_sel;
    logic       rw;
  } addr_byte_t;

  function automatic int unsigned nv_cycle_count(int unsigned clk_hz, int unsigned time_us);
    return ((clk_hz / 1000) * time_us) / 1000;
  endfunction
endpackage

// File: rtl/nvp_addr_match.sv
module nvp_addr_match #(
  parameter logic [3:0] DEV_TYPE = 4'b0101,
  parameter logic [2:0] DEV_SEL  = 3'b010
) (
  input  logic [7:0] addr_byte,
  output logic       hit
);
  import nvp_pkg::*;
  addr_byte_t ab;
  always_comb begin
    ab  = addr_byte_t'(addr_byte);
    hit = (ab.dev_type == DEV_TYPE) && (ab.dev_sel == DEV_SEL);
  end
endmodule

// File: rtl/nvp_arm_tracker.sv
module nvp_arm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic nv_write_req,
  input  logic cmd_en,
  output logic launch
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (ev_start || ev_stop) armed <= 1'b0;
    else if (nv_write_req && cmd_en) armed <= 1'b1;
  end

  assign launch = ev_stop && armed && !ev_start;

  assert_start_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !launch);
endmodule

// File: rtl/nvp_write_timer.sv
module nvp_write_timer #(
  parameter int unsigned NV_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int unsigned CW = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NV_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1;
      cnt  <= LAST;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assert_busy_after_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy);
endmodule

// File: rtl/nvp_poll_responder.sv
module nvp_poll_responder #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned NV_TIME_US = 5000,
  parameter logic [3:0]  DEV_TYPE   = 4'b0101,
  parameter logic [2:0]  DEV_SEL    = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       addr_valid,
  input  logic [7:0] addr_byte,
  input  logic       nv_write_req,
  output logic       ack_valid,
  output logic       ack,
  output logic       busy,
  output logic       cmd_en
);
  import nvp_pkg::*;
  localparam int unsigned NV_CYCLES = nv_cycle_count(CLK_HZ, NV_TIME_US);

  logic hit, launch, ack_now;

  nvp_addr_match #(.DEV_TYPE(DEV_TYPE), .DEV_SEL(DEV_SEL)) u_match (
    .addr_byte(addr_byte), .hit(hit));

  nvp_arm_tracker u_arm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .nv_write_req(nv_write_req), .cmd_en(cmd_en), .launch(launch));

  nvp_write_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy));

  assign ack_now = addr_valid && hit && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      cmd_en    <= 1'b0;
    end else begin
      ack_valid <= addr_valid;
      ack       <= ack_now;
      if (ev_start || ev_stop) cmd_en <= 1'b0;
      else if (ack_now)        cmd_en <= 1'b1;
    end
  end

  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && busy) |=> (ack_valid && !ack));
  assert_mismatch_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !hit) |=> !ack);
  assert_cmd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_en);
  assert_launch_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_valid);
endmodule

// File: tb/nvp_poll_responder_bench.sv
module nvp_poll_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned NV_TIME_US = 5000;
  localparam int NV = 50;
  localparam logic [7:0] A_WR = 8'h54, A_RD = 8'h55, A_BAD = 8'h5C, A_BAD2 = 8'hA4;

  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, addr_valid = 0, nv_write_req = 0;
  logic [7:0] addr_byte = 0;
  logic ack_valid, ack, busy, cmd_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvp_poll_responder #(.CLK_HZ(CLK_HZ), .NV_TIME_US(NV_TIME_US)) u_nvp_poll_responder (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .nv_write_req(nv_write_req),
    .ack_valid(ack_valid), .ack(ack), .busy(busy), .cmd_en(cmd_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_left = 0; bit m_armed = 0, m_cmd = 0, m_ackv = 0, m_ack = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_armed = 0; m_cmd = 0; m_ackv = 0; m_ack = 0;
    end else begin
      bit hit, ackn, go;
      hit  = (addr_byte[7:1] == A_WR[7:1]);
      ackn = addr_valid && hit && (m_left == 0);
      go   = ev_stop && m_armed && !ev_start;
      m_ackv = addr_valid;
      m_ack  = ackn;
      if (ev_start || ev_stop) m_armed = 0;
      else if (nv_write_req && m_cmd) m_armed = 1;
      if (ev_start || ev_stop) m_cmd = 0;
      else if (ackn) m_cmd = 1;
      if (go && m_left == 0) m_left = NV;
      else if (m_left > 0) m_left--;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(ack_valid == m_ackv, "R2 ack_valid", ack_valid, m_ackv);
    chk(ack == m_ack, "R2 ack", ack, m_ack);
    chk(busy == (m_left > 0), "R8 busy", busy, m_left > 0);
    chk(cmd_en == m_cmd, "R5 cmd_en", cmd_en, m_cmd);
  end

  // busy-length monitor for R8
  int run = 0;
  always @(negedge clk) if (rst_n && !done) begin
    if (busy) run++;
    else if (run != 0) begin
      chk(run == NV, "R8 busy length", run, NV);
      run = 0;
    end
  end

  task automatic pulse_start(); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic pulse_stop();  ev_stop = 1;  @(negedge clk); ev_stop = 0;  endtask
  task automatic pulse_nv();    nv_write_req = 1; @(negedge clk); nv_write_req = 0; endtask
  task automatic send_addr(input logic [7:0] b);
    addr_valid = 1; addr_byte = b; @(negedge clk); addr_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk({busy, ack_valid, ack, cmd_en} == 4'b0, "R1 reset outputs", {busy, ack_valid, ack, cmd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    // idle mismatch
    pulse_start(); send_addr(A_BAD);
    chk(ack_valid && !ack, "R4 idle mismatch nack", ack, 0);
    send_addr(A_BAD2);
    chk(!ack && !cmd_en, "R4 idle mismatch2 nack", ack, 0);
    pulse_stop();
    // read-form address acknowledged, no arm on plain stop
    pulse_start(); send_addr(A_RD);
    chk(ack_valid && ack, "R3 read address ack", ack, 1);
    chk(cmd_en, "R5 cmd_en after ack", cmd_en, 1);
    pulse_stop();
    chk(!busy && !cmd_en, "R7 stop without arm", busy, 0);
    // aborted nv write
    pulse_start(); send_addr(A_WR); pulse_nv();
    pulse_start();
    chk(!cmd_en, "R5 cmd_en drops on start", cmd_en, 0);
    send_addr(A_BAD); pulse_stop();
    @(negedge clk);
    chk(!busy, "R7 aborted write no busy", busy, 0);
    // valid nv write
    pulse_start(); send_addr(A_WR);
    chk(ack, "R2 write address ack", ack, 1);
    @(negedge clk); pulse_nv(); @(negedge clk);
    pulse_stop();
    chk(busy, "R6 busy after stop", busy, 1);
    // polls during busy
    for (int i = 0; i < 3; i++) begin
      pulse_start(); send_addr(A_WR);
      chk(ack_valid && !ack, "R9 busy poll write nack", ack, 0);
      pulse_stop();
      pulse_start(); send_addr(A_RD);
      chk(ack_valid && !ack, "R9 busy poll read nack R3", ack, 0);
      pulse_nv();
      chk(!cmd_en, "R9 cmd_en low while busy", cmd_en, 0);
      send_addr(A_BAD);
      chk(!ack, "R4 busy mismatch nack", ack, 0);
      pulse_stop();
      chk(busy, "R9 nv_write_req ignored, still busy", busy, 1);
    end
    while (busy) @(negedge clk);
    pulse_start(); send_addr(A_RD);
    chk(ack_valid && ack, "R10 first poll after busy (read)", ack, 1);
    pulse_stop();
    @(negedge clk);
    chk(!busy, "R7 stop without nv arm", busy, 0);
    // second cycle, poll with write bit
    pulse_start(); send_addr(A_WR); pulse_nv(); pulse_stop();
    chk(busy, "R6 second launch", busy, 1);
    while (busy) begin
      pulse_start(); send_addr(A_WR);
      if (busy) chk(!ack, "R9 repeated poll nack", ack, 0);
      pulse_stop();
    end
    pulse_start(); send_addr(A_WR);
    chk(ack, "R10 first poll after busy (write)", ack, 1);
    pulse_stop();
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule